// File: doc/BRIEF.md
# MDIO Management Master

This block drives a two-wire management bus toward one or more Ethernet PHYs. Software reaches it through two 32-bit words in a small register window. One word holds the MDC clock divider and a preamble switch. The other word holds a complete 32-bit management frame.

Writing the frame word starts a transaction. The block generates MDC from the system clock and, if enabled, sends a preamble of ones. It then drives the frame onto MDIO, most significant bit first. For a read opcode it lets go of MDIO during turnaround and stores the 16 bits the PHY returns in the low half of the frame word. A busy flag in the control word covers the whole transaction. Software polls that flag, then reads the result.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both register words read as zero, MDC is low and the MDIO output enable is low.
- R2: A write at byte offset 0x0 stores the divider in bits 6:0 and the preamble enable in bit 7. Reading offset 0x0 returns both fields, with the busy flag in bit 8.
- R3: A write at byte offset 0x4 while idle loads the frame word and sets busy from the next cycle. Busy stays set for exactly N x 2 x H system cycles, where N is 32 frame bits plus 32 preamble bits when the preamble is enabled.
- R4: The MDC half period H is the divider value in system cycles, and a divider of zero counts as one. MDC rises only while busy.
- R5: With the preamble enabled, 32 ones go out before frame bit 31. With it disabled, frame bit 31 is the first bit sent.
- R6: Frame bits go out from bit 31 down to bit 0, each sampled by the PHY on a rising MDC edge. MDIO changes only on a falling MDC edge while it is driven.
- R7: A frame whose bits 29:28 equal 2'b10 is a read. For a read, MDIO is driven through frame bit 17 and released from frame bit 16 to the end. Any other opcode keeps MDIO driven for the whole frame.
- R8: After a read, bits 15:0 of the frame word hold the 16 bits sampled on the rising MDC edges of frame bits 15 down to 0. Bits 31:16 keep the value written.
- R9: A write at offset 0x4 while busy is ignored. The frame in progress, its length and the stored word are unchanged.
- R10: After the last bit, busy clears on the falling MDC edge that ends that bit. When idle, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Byte offset: 0x0 control, 0x4 frame |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| mdio_i | input | 1 | MDIO pad input |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe_o | output | 1 | MDIO pad output enable |

## Verification
Two events can fall in the same cycle: a register write to the frame word and a transaction still in progress. A single write can also both load the frame and sample the busy state. The bench provokes the clash by writing a different frame word partway through a transfer. It then judges the result from the captured bit stream, the measured busy length and the word read back afterward, all of which must match the first frame. Random transactions cover other combinations: a read capturing PHY data, a preamble ending on a falling edge, and the turnaround release.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned REG_AW   = 3;
  localparam int unsigned DW       = 32;
  localparam int unsigned FRAME_W  = 32;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned DIV_W    = 7;
  localparam int unsigned TA_LO    = 16;
  localparam logic [REG_AW-1:0] CTRL_OFS = 3'h0;
  localparam logic [REG_AW-1:0] DATA_OFS = 3'h4;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, half_m1;
  logic             mdc_q, wrap;

  // zero divider behaves as one
  assign half_m1 = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign wrap    = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned FW  = FRAME_W,
  parameter int unsigned PRE = PRE_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [FW-1:0] cmd_i,
  input  logic          pre_en_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdio_i,
  output logic          busy_o,
  output logic [FW-1:0] frame_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  localparam int unsigned IDX_W = $clog2(FW);
  localparam int unsigned PRE_W = $clog2(PRE + 1);

  logic             busy_q;
  logic [FW-1:0]    frame_q;
  logic [PRE_W-1:0] pre_left_q;
  logic [IDX_W-1:0] idx_q;
  logic             is_rd, in_frame, released, capture;

  assign is_rd    = (frame_q[FW-3:FW-4] == OP_RD);
  assign in_frame = (pre_left_q == '0);
  assign released = is_rd && in_frame && (idx_q <= IDX_W'(TA_LO));
  assign capture  = is_rd && in_frame && (idx_q < IDX_W'(TA_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      frame_q    <= '0;
      pre_left_q <= '0;
      idx_q      <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q     <= 1'b1;
        frame_q    <= cmd_i;
        pre_left_q <= pre_en_i ? PRE_W'(PRE) : '0;
        idx_q      <= IDX_W'(FW - 1);
      end
    end else begin
      if (rise_i && capture) frame_q[idx_q] <= mdio_i;
      if (fall_i) begin
        if (!in_frame)         pre_left_q <= pre_left_q - PRE_W'(1);
        else if (idx_q == '0)  busy_q     <= 1'b0;
        else                   idx_q      <= idx_q - IDX_W'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign frame_o   = frame_q;
  assign mdio_o    = (busy_q && in_frame) ? frame_q[idx_q] : 1'b1;
  assign mdio_oe_o = busy_q && !released;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int unsigned CTRL_PAD = DW - DIV_W - 2;

  logic [DIV_W-1:0]   div_q;
  logic               pre_en_q;
  logic               busy, rise, fall, launch;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      pre_en_q <= 1'b0;
    end else if (reg_we_i && reg_addr_i == CTRL_OFS) begin
      div_q    <= reg_wdata_i[DIV_W-1:0];
      pre_en_q <= reg_wdata_i[DIV_W];
    end
  end

  assign launch = reg_we_i && (reg_addr_i == DATA_OFS);

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng #(.FW(FRAME_W), .PRE(PRE_LEN)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .cmd_i     (reg_wdata_i),
    .pre_en_i  (pre_en_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .frame_o   (frame),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  always_comb begin
    case (reg_addr_i)
      CTRL_OFS: reg_rdata_o = {{CTRL_PAD{1'b0}}, busy, pre_en_q, div_q};
      DATA_OFS: reg_rdata_o = frame;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        oe_i,
  input logic [15:0] frame_hi_i
);
  assert_mdc_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_i) |-> busy_i);

  assert_mdio_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i) && !$fell(mdc_i)) |-> $stable(mdio_i));

  assert_release_read_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !oe_i) |-> (frame_hi_i[13:12] == 2'b10));

  assert_frame_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_i) && busy_i) |-> $stable(frame_hi_i));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !oe_i));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy),
  .mdc_i      (mdc_o),
  .mdio_i     (mdio_o),
  .oe_i       (mdio_oe_o),
  .frame_hi_i (frame[31:16])
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdio_in = 1'b1;
  logic        mdc, mdio_out, mdio_oe;

  int total = 0;
  int fails = 0;

  logic        rec_v  [0:63];
  logic        rec_oe [0:63];
  int          k = 0;
  logic [31:0] cur_cmd = '0;
  logic        cur_pre = 1'b0;
  logic [15:0] phy_rd = '0;

  always #2 clk = ~clk;

  mdio_mgmt_master u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .reg_we_i (reg_we), .reg_addr_i (reg_addr),
    .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata), .mdio_i (mdio_in),
    .mdc_o (mdc), .mdio_o (mdio_out), .mdio_oe_o (mdio_oe)
  );

  function automatic int frame_idx(input int bit_no, input logic pre);
    return 31 - (bit_no - (pre ? 32 : 0));
  endfunction

  function automatic logic phy_bit(input int bit_no);
    int idx = frame_idx(bit_no, cur_pre);
    if (cur_cmd[29:28] == 2'b10 && idx >= 0 && idx <= 15) return phy_rd[idx];
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    if (k < 64) begin rec_v[k] = mdio_out; rec_oe[k] = mdio_oe; end
    k = k + 1;
  end
  always @(negedge mdc) mdio_in = phy_bit(k);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 3'h0;
  endtask

  task automatic run_txn(input int div, input logic pre, input logic [31:0] cmd,
                         input logic [15:0] rd, input bit poke);
    int n_bits, h, cyc, bad_v, bad_oe;
    logic rd_op;
    logic [31:0] exp_data;
    wr(3'h0, {23'b0, pre, div[6:0]});
    #1;
    chk(reg_rdata == {23'b0, pre, div[6:0]}, "R2 ctrl readback", reg_rdata, {23'b0, pre, div[6:0]});
    n_bits = pre ? 64 : 32;
    h = (div == 0) ? 1 : div;
    rd_op = (cmd[29:28] == 2'b10);
    cur_cmd = cmd; cur_pre = pre; phy_rd = rd; k = 0; mdio_in = 1'b1;
    wr(3'h4, cmd);
    cyc = 0;
    while (cyc < 20000) begin
      #1;
      if (!reg_rdata[8]) break;
      cyc++;
      if (poke && cyc == 6) begin reg_we = 1'b1; reg_addr = 3'h4; reg_wdata = ~cmd; end
      @(negedge clk); reg_we = 1'b0; reg_addr = 3'h0;
    end
    chk(cyc == n_bits * 2 * h, poke ? "R9/R3 busy length" : "R3/R4 busy length", cyc, n_bits * 2 * h);
    chk(k == n_bits, "R5 bit count", k, n_bits);
    bad_v = 0; bad_oe = 0;
    for (int b = 0; b < n_bits && b < 64; b++) begin
      int idx = frame_idx(b, pre);
      logic exp_oe = !(rd_op && idx >= 0 && idx <= 16);
      if (rec_oe[b] !== exp_oe) bad_oe++;
      if (exp_oe && rec_v[b] !== ((idx > 31) ? 1'b1 : cmd[idx])) bad_v++;
    end
    chk(bad_v == 0, "R5/R6 driven bits", bad_v, 0);
    chk(bad_oe == 0, "R7 output enable", bad_oe, 0);
    chk(!mdc && !mdio_oe, "R10 idle after frame", {mdc, mdio_oe}, 0);
    reg_addr = 3'h4; #1;
    exp_data = rd_op ? {cmd[31:16], rd} : cmd;
    chk(reg_rdata == exp_data, poke ? "R9 frame word" : "R8 frame word", reg_rdata, exp_data);
    reg_addr = 3'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1729);
    repeat (3) @(negedge clk);
    #1;
    chk(reg_rdata == 32'h0, "R1 ctrl reset", reg_rdata, 0);
    chk(!mdc && !mdio_oe, "R1 pins reset", {mdc, mdio_oe}, 0);
    reg_addr = 3'h4; #1;
    chk(reg_rdata == 32'h0, "R1 frame reset", reg_rdata, 0);
    reg_addr = 3'h0;
    @(negedge clk); rst_ni = 1'b1;
    run_txn(26, 1'b1, mk_cmd(2'b01, 5'd3, 5'd0, 16'h1140), 16'h0, 1'b0);
    run_txn(0, 1'b0, mk_cmd(2'b10, 5'd1, 5'd2, 16'h0), 16'hA5C3, 1'b0);
    run_txn(1, 1'b1, mk_cmd(2'b10, 5'd31, 5'd31, 16'h0), 16'h8001, 1'b0);
    run_txn(2, 1'b0, mk_cmd(2'b01, 5'd7, 5'd9, 16'hFFFF), 16'h0, 1'b1);
    run_txn(3, 1'b1, mk_cmd(2'b10, 5'd4, 5'd17, 16'h0), 16'h5A5A, 1'b1);
    for (int t = 0; t < 8; t++) begin
      int d = 1 + ($urandom % 5);
      logic p = $urandom % 2;
      logic [1:0] op = ($urandom % 2) ? 2'b10 : 2'b01;
      run_txn(d, p, mk_cmd(op, 5'($urandom), 5'($urandom), (op == 2'b01) ? 16'($urandom) : 16'h0),
              16'($urandom), 1'b0);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule